// File: doc/BRIEF.md
# Nine-Bit SPI Register Writer

This block turns one register-write request into a short burst on a write-only three-wire serial link of the kind used to set up small display controllers. A request carries an 8-bit register address, a length code and up to two data bytes. The block sends a command word holding the address, then zero, one or two data words, all under one chip-select assertion. Every word is nine bits wide, and its leading bit tells the receiver whether the remaining eight bits are an address or a data byte.

The serial clock is made by dividing the system clock by a parameter and follows SPI mode 3. The clock rests high, the receiver samples on rising edges, and the block changes MOSI only when the clock falls. A valid/ready pair takes in requests. `busy_o` is high while a transfer or the idle gap after it is still running. `done_o` pulses once when chip select goes back high.

Top module: `nbsw_writer`

## Requirements
- R1: After reset, `cs_no` and `sclk_o` are high, `req_ready_o` is high, and `busy_o` and `done_o` are low.
- R2: Each word has nine bits and is sent most significant bit first. The command word is first, with bit 8 = 0 and the register address in bits 7:0.
- R3: Every data word has bit 8 = 1, with one data byte in bits 7:0.
- R4: Length code 0 sends 1 word, code 1 sends 2 words and code 2 sends 3 words. Code 3 is handled as code 2.
- R5: With code 2, `req_data_i[15:8]` is sent before `req_data_i[7:0]`. With code 1, the single data byte is `req_data_i[7:0]`.
- R6: SPI mode 3: `sclk_o` is high whenever `cs_no` is high. While `cs_no` stays low, `mosi_o` changes only in the cycle where `sclk_o` falls.
- R7: One `sclk_o` period is 2*CLK_DIV system clock cycles, with no stretching between the words of a transfer.
- R8: `cs_no` falls exactly once and rises exactly once per request, so it stays low across the command and all its data words.
- R9: Between the rise of `cs_no` and its next fall there are at least 2*CLK_DIV system cycles.
- R10: A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high, and `cs_no` goes low on the next cycle. `req_ready_o` stays low from that point until the idle gap has ended, so a request held during that time waits.
- R11: `done_o` is high for exactly one cycle, and that cycle is the one in which `cs_no` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can take a request |
| req_addr_i | input | 8 | Register address for the command word |
| req_nbytes_i | input | 2 | Number of data bytes (0, 1, 2; 3 is treated as 2) |
| req_data_i | input | 16 | Data value; high byte first when two are sent |
| sclk_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data out |
| cs_no | output | 1 | Chip select, active low |
| busy_o | output | 1 | Transfer or post-transfer gap in progress |
| done_o | output | 1 | One-cycle pulse when chip select is released |

## Verification
The bench sends a command-only write, single-byte writes and two-byte writes, and a length code of 3. Each case tells a different framing path apart: with one byte the low half of the data must be used, with two bytes the high half must come first, and code 3 must give the same result as code 2. The data values are asymmetric, such as 0xFFF9, 0x0D0E and 0x1234, so that a swapped byte order or a wrong flag bit shows up. A request held valid during the gap after a transfer checks that the new request waits and that the idle time with chip select high is long enough. Clock period, continuity of chip select and the `done_o` timing are measured on every transfer.

// File: rtl/nbsw_pkg.sv
package nbsw_pkg;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = BYTE_W + 1;
  localparam int BIT_IDX_W = $clog2(WORD_W);
  localparam int MAX_DATA  = 2;
  localparam int WIDX_W    = $clog2(MAX_DATA + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_GAP
  } nbsw_state_e;
endpackage

// File: rtl/nbsw_tick_gen.sv
module nbsw_tick_gen #(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = run_i && (cnt_q == LAST);
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nbsw_word_mux.sv
module nbsw_word_mux
  import nbsw_pkg::*;
(
  input  logic [BYTE_W-1:0]    addr_i,
  input  logic [2*BYTE_W-1:0]  data_i,
  input  logic [WIDX_W-1:0]    last_i,
  input  logic [WIDX_W-1:0]    word_idx_i,
  input  logic [BIT_IDX_W-1:0] bit_idx_i,
  output logic                 bit_o
);
  logic [WORD_W-1:0] word, word_sh;
  logic [BYTE_W-1:0] hi_byte, lo_byte;

  assign hi_byte = data_i[2*BYTE_W-1:BYTE_W];
  assign lo_byte = data_i[BYTE_W-1:0];

  always_comb begin
    // leading bit: 0 marks the address word, 1 marks a data word
    if (word_idx_i == '0)
      word = {1'b0, addr_i};
    else if (word_idx_i == WIDX_W'(1) && last_i != WIDX_W'(1))
      word = {1'b1, hi_byte};
    else
      word = {1'b1, lo_byte};
    word_sh = word << bit_idx_i;
    bit_o   = word_sh[WORD_W-1];
  end
endmodule

// File: rtl/nbsw_writer.sv
module nbsw_writer
  import nbsw_pkg::*;
#(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [7:0]  req_addr_i,
  input  logic [1:0]  req_nbytes_i,
  input  logic [15:0] req_data_i,
  output logic        sclk_o,
  output logic        mosi_o,
  output logic        cs_no,
  output logic        busy_o,
  output logic        done_o
);
  localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(WORD_W - 1);
  localparam logic [WIDX_W-1:0]    MAX_IDX  = WIDX_W'(MAX_DATA);

  nbsw_state_e           state_q, state_d;
  logic [BYTE_W-1:0]     addr_q, addr_d;
  logic [2*BYTE_W-1:0]   data_q, data_d;
  logic [WIDX_W-1:0]     last_q, last_d;
  logic [WIDX_W-1:0]     widx_q, widx_d;
  logic [BIT_IDX_W-1:0]  bidx_q, bidx_d;
  logic                  sclk_q, sclk_d;
  logic                  mosi_q, mosi_d;
  logic                  cs_n_q, cs_n_d;
  logic                  done_q, done_d;
  logic                  gap_q, gap_d;
  logic                  tick, cur_bit, take;

  nbsw_tick_gen #(.CLK_DIV(CLK_DIV)) tick_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q != ST_IDLE),
    .tick_o(tick)
  );

  nbsw_word_mux mux_i (
    .addr_i    (addr_q),
    .data_i    (data_q),
    .last_i    (last_q),
    .word_idx_i(widx_q),
    .bit_idx_i (bidx_q),
    .bit_o     (cur_bit)
  );

  assign take = (state_q == ST_IDLE) && req_valid_i;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    data_d  = data_q;
    last_d  = last_q;
    widx_d  = widx_q;
    bidx_d  = bidx_q;
    sclk_d  = sclk_q;
    mosi_d  = mosi_q;
    cs_n_d  = cs_n_q;
    gap_d   = gap_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (take) begin
        addr_d  = req_addr_i;
        data_d  = req_data_i;
        last_d  = (req_nbytes_i > 2'd2) ? MAX_IDX : WIDX_W'(req_nbytes_i);
        widx_d  = '0;
        bidx_d  = '0;
        cs_n_d  = 1'b0;
        mosi_d  = 1'b0;  // first bit of the address word is its flag bit
        state_d = ST_LEAD;
      end
      ST_LEAD: if (tick) state_d = ST_SHIFT;
      ST_SHIFT: if (tick) begin
        if (sclk_q) begin
          sclk_d = 1'b0;
          mosi_d = cur_bit;
        end else begin
          sclk_d = 1'b1;
          if (bidx_q == LAST_BIT) begin
            bidx_d = '0;
            if (widx_q == last_q) state_d = ST_TRAIL;
            else                  widx_d  = widx_q + 1'b1;
          end else begin
            bidx_d = bidx_q + 1'b1;
          end
        end
      end
      ST_TRAIL: if (tick) begin
        cs_n_d  = 1'b1;
        done_d  = 1'b1;
        gap_d   = 1'b0;
        state_d = ST_GAP;
      end
      ST_GAP: if (tick) begin
        if (gap_q) state_d = ST_IDLE;
        else       gap_d   = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      last_q  <= '0;
      widx_q  <= '0;
      bidx_q  <= '0;
      sclk_q  <= 1'b1;
      mosi_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      gap_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      last_q  <= last_d;
      widx_q  <= widx_d;
      bidx_q  <= bidx_d;
      sclk_q  <= sclk_d;
      mosi_q  <= mosi_d;
      cs_n_q  <= cs_n_d;
      done_q  <= done_d;
      gap_q   <= gap_d;
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE);
  assign sclk_o      = sclk_q;
  assign mosi_o      = mosi_q;
  assign cs_no       = cs_n_q;
  assign done_o      = done_q;
endmodule

// File: rtl/nbsw_writer_chk.sv
module nbsw_writer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic cs_no,
  input logic done_o
);
  // R6
  sclk_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o);

  // R6
  mosi_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !$past(cs_no) && (mosi_o != $past(mosi_o))) |-> $fell(sclk_o));

  // R11
  done_at_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(cs_no));

  // R11
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  not_ready_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !req_ready_o);

  // R10
  accept_selects_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !cs_no);
endmodule

bind nbsw_writer nbsw_writer_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .sclk_o     (sclk_o),
  .mosi_o     (mosi_o),
  .cs_no      (cs_no),
  .done_o     (done_o)
);

// File: tb/nbsw_writer_tb_top.sv
`timescale 1ns/1ps
module nbsw_writer_tb_top;
  localparam int DIV = 3;
  localparam longint PER_NS = 2 * DIV * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_addr = '0;
  logic [1:0] req_nb = '0;
  logic [15:0] req_data = '0;
  logic req_ready, sclk, mosi, cs_n, busy, done;

  always #4 clk = ~clk;

  nbsw_writer #(.CLK_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_nbytes_i(req_nb), .req_data_i(req_data),
    .sclk_o(sclk), .mosi_o(mosi), .cs_no(cs_n), .busy_o(busy), .done_o(done)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // monitor state
  logic [8:0] words [0:7];
  logic [8:0] sh;
  int nwords, nbits, cs_falls, cs_rises, per_bad, ready_bad, mosi_bad, idle_bad;
  bit have_rise, have_csr;
  longint last_rise, cs_rise_t, last_gap;
  logic prev_cs, prev_sclk, prev_mosi;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    nwords = 0; nbits = 0; cs_falls = 0; cs_rises = 0;
    per_bad = 0; ready_bad = 0; mosi_bad = 0; have_rise = 0;
  endtask

  always @(posedge sclk) if (rst_n && !cs_n) begin
    sh = {sh[7:0], mosi};
    nbits++;
    if (nbits % 9 == 0) begin
      if (nwords < 8) words[nwords] = sh;
      nwords++;
    end
    if (have_rise && ($time - last_rise) != PER_NS) per_bad++;
    last_rise = $time;
    have_rise = 1;
  end

  always @(negedge cs_n) if (rst_n) begin
    cs_falls++;
    if (have_csr) last_gap = $time - cs_rise_t;
  end

  always @(posedge cs_n) if (rst_n) begin
    cs_rises++;
    cs_rise_t = $time;
    have_csr = 1;
  end

  always @(negedge clk) if (rst_n) begin
    if (!cs_n && req_ready) ready_bad++;
    if (cs_n && !sclk) idle_bad++;
    if (!cs_n && !prev_cs && mosi != prev_mosi && !(prev_sclk && !sclk)) mosi_bad++;
    prev_cs = cs_n; prev_sclk = sclk; prev_mosi = mosi;
  end

  task automatic send(input logic [7:0] a, input logic [1:0] nb, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_nb = nb; req_data = d;
    for (int i = 0; i < 1000; i++) begin
      if (req_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R11 done seen", done, 1);
    chk(cs_n == 1'b1, "R11 cs released with done", cs_n, 1);
    chk(req_ready == 1'b0, "R10 ready low in gap", req_ready, 0);
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", done, 0);
  endtask

  task automatic check_words(input logic [7:0] a, input logic [1:0] nb, input logic [15:0] d);
    int nw = ((nb > 2) ? 2 : int'(nb)) + 1;
    logic [8:0] e1 = (nw == 2) ? {1'b1, d[7:0]} : {1'b1, d[15:8]};
    logic [8:0] e2 = {1'b1, d[7:0]};
    chk(nwords == nw, "R4 word count", nwords, nw);
    chk(nbits == nw * 9, "R2 nine bits per word", nbits, nw * 9);
    chk(words[0] == {1'b0, a}, "R2 command word", words[0], {1'b0, a});
    if (nw >= 2) chk(words[1] == e1, (nw == 3) ? "R5 high byte first" : "R3 data word", words[1], e1);
    if (nw == 3) chk(words[2] == e2, "R5 low byte second", words[2], e2);
    chk(cs_falls == 1 && cs_rises == 1, "R8 single select window", cs_falls * 16 + cs_rises, 17);
    chk(per_bad == 0, "R7 sclk period", per_bad, 0);
    chk(ready_bad == 0, "R10 ready low while selected", ready_bad, 0);
    chk(mosi_bad == 0, "R6 mosi changes on falling edge", mosi_bad, 0);
  endtask

  task automatic test_write(input logic [7:0] a, input logic [1:0] nb, input logic [15:0] d);
    repeat (2 * DIV * 2) @(negedge clk);
    clear_mon();
    send(a, nb, d);
    wait_done();
    check_words(a, nb, d);
  endtask

  task automatic test_reset();
    chk(cs_n == 1 && sclk == 1, "R1 cs and sclk idle high", {cs_n, sclk}, 2'b11);
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
    chk(busy == 0 && done == 0, "R1 busy and done low", {busy, done}, 0);
  endtask

  task automatic test_back_to_back();
    repeat (2 * DIV * 2) @(negedge clk);
    clear_mon();
    send(8'h29, 2'd0, 16'h0);
    wait_done();
    check_words(8'h29, 2'd0, 16'h0);
    // request raised right after release; must wait out the gap
    clear_mon();
    send(8'hC3, 2'd2, 16'h2040);
    chk(last_gap >= PER_NS, "R9 idle gap", last_gap, PER_NS);
    wait_done();
    check_words(8'hC3, 2'd2, 16'h2040);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_write(8'h11, 2'd0, 16'hFFFF);   // command only
    test_write(8'h3B, 2'd1, 16'hC3A5);   // one byte uses low half
    test_write(8'hB8, 2'd2, 16'hFFF9);   // two bytes
    test_write(8'hD3, 2'd2, 16'h0D0E);
    test_write(8'h5A, 2'd3, 16'h1234);   // code 3 acts as code 2
    test_back_to_back();
    chk(idle_bad == 0, "R6 sclk high while deselected", idle_bad, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule